// File: doc/BRIEF.md
# Banked SPI Register Access Sequencer

This block is an SPI master that turns single host requests into complete command frames for a peripheral whose control registers are split across four banks. The host presents an operation, an 8-bit register address, write data and a stream length. The sequencer then drives chip select, the serial clock and the data line itself, and signals completion with a one-cycle done pulse. Bytes read back are returned one at a time with a valid strobe. During a buffer write, each outgoing data byte is taken live from the host, and a take strobe tells the host to present the next one.

Address bits 6:5 name the bank. The sequencer remembers which bank it last selected. When a banked request targets a different bank, or no bank has been selected since reset, it first sends two bank-select frames. When the bank is unchanged it goes straight to the access. Registers with address bit 7 set need one filler byte before their read data is valid, and the sequencer inserts that byte automatically. A 16-bit write becomes two frames: the low byte goes to the register and the high byte to its neighbour.

Top module: `banked_spi_seq`

## Requirements
- R1: Each frame starts with a command byte equal to the operation's opcode ORed with address bits 4:0. The opcodes are 0x00 for a control read, 0x40 for a control write, 0x80 for a bit set, 0xA0 for a bit clear, 0x3A for a buffer read and 0x7A for a buffer write. Bytes are sent MSB first in SPI mode 0: SCK idles low, MISO is sampled on the rising edge, and MOSI changes only while SCK is low.
- R2: A bank switch is two frames, sent before the access frame: {0xBF, 0x03}, which clears both select bits of register 0x1F, then {0x9F, bank}, which sets the new value of address bits 6:5.
- R3: The bank of the last switch is remembered. A banked request whose bank matches it sends no switch. The first banked request after reset always switches. Buffer operations neither switch nor change the remembered bank.
- R4: A control read is the frame {cmd, 0x00}, and the second byte received is returned on rdata_o with one rvalid_o pulse. When address bit 7 is set, the frame is {cmd, 0x00, 0x00} and the third byte received is returned.
- R5: A control write, bit set or bit clear is the two-byte frame {cmd, wdata_i[7:0]}.
- R6: A pair write (op 4) sends two frames: {0x40|addr[4:0], wdata_i[7:0]}, then {0x40|((addr[4:0]+1) mod 32), wdata_i[15:8]}.
- R7: A buffer read (op 5) is one frame: 0x3A followed by len_i bytes of 0x00. Each received byte is returned with its own rvalid_o pulse. A length of 0 sends only the command byte.
- R8: A buffer write (op 6) is one frame: 0x7A followed by len_i data bytes. Each data byte is sampled from wdata_i[7:0] as it is loaded, and wtake_o pulses for one cycle at that moment.
- R9: cs_no stays high for at least SCK_DIV clock cycles between frames and after the last frame, and SCK is low whenever cs_no is high.
- R10: The op field is 0 for a control read, 1 for a control write, 2 for a bit set, 3 for a bit clear, 4 for a pair write, 5 for a buffer read and 6 for a buffer write. A request is accepted only while busy_o is low, and op 7 is never accepted. Requests made while busy have no effect. busy_o is high from the cycle after acceptance until done_o pulses for one cycle.
- R11: After reset, cs_no is high, sck_o is low, and busy_o, done_o, rvalid_o and wtake_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled while idle |
| op_i | input | 3 | Operation code (see R10) |
| addr_i | input | 8 | Register address: bank in bits 6:5, dummy-read flag in bit 7 |
| wdata_i | input | 16 | Write data; bits 7:0 are live during a buffer write |
| len_i | input | LEN_W | Data byte count for buffer operations |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last byte captured |
| rvalid_o | output | 1 | rdata_o updated this cycle |
| wtake_o | output | 1 | wdata_i[7:0] consumed; present the next byte |
| cs_no | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench starts with directed requests. It runs a first access after reset, then repeats the bank to confirm the switch is skipped, then changes the bank to confirm it comes back. It reads with and without address bit 7 set, which shows whether the filler byte is present. A pair write at the top register of a bank checks that the high-byte address wraps. Buffer streams of length zero and non-zero, with buffer operations placed between banked ones, show that streams leave the remembered bank alone. A request with op 7 and a request raised while busy are each shown to produce no frame. A fixed-seed random mix of operations, addresses, data and lengths follows. Each request's frames and returned bytes are compared with a model that keeps its own copy of the remembered bank. A slave that answers with a position-dependent byte pattern shows which byte was captured.

// File: rtl/banked_spi_seq_pkg.sv
package banked_spi_seq_pkg;

  typedef enum logic [2:0] {
    OP_RD     = 3'd0,
    OP_WR     = 3'd1,
    OP_BSET   = 3'd2,
    OP_BCLR   = 3'd3,
    OP_PAIR   = 3'd4,
    OP_BUF_RD = 3'd5,
    OP_BUF_WR = 3'd6,
    OP_NONE   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    STEP_BCLR = 2'd0,
    STEP_BSET = 2'd1,
    STEP_MAIN = 2'd2,
    STEP_HIGH = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_BYTE = 2'd2,
    ST_GAP  = 2'd3
  } state_e;

  function automatic logic is_stream(op_e op);
    return (op == OP_BUF_RD) || (op == OP_BUF_WR);
  endfunction

endpackage

// File: rtl/banked_spi_seq_shift.sv
module banked_spi_seq_shift #(
  parameter int SCK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);
  localparam int HALF  = SCK_DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_q, rx_q;
  logic             sck_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      sck_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          tx_q     <= tx_i;
          cnt_q    <= '0;
          bit_q    <= '0;
          sck_q    <= 1'b0;
        end
      end else if (cnt_q == CNT_W'(HALF - 1)) begin
        cnt_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[6:0], miso_i};
        end else begin
          // falling edge: advance MOSI while SCK is low
          sck_q <= 1'b0;
          tx_q  <= {tx_q[6:0], 1'b0};
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = tx_q[7];
  assign rx_o   = rx_q;
  assign done_o = done_q;
endmodule

// File: rtl/banked_spi_seq_bank.sv
module banked_spi_seq_bank (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] bank_i,
  input  logic       load_i,
  output logic       match_o
);
  logic       valid_q;
  logic [1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      bank_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      bank_q  <= bank_i;
    end
  end

  assign match_o = valid_q && (bank_q == bank_i);
endmodule

// File: rtl/banked_spi_seq_frame.sv
module banked_spi_seq_frame
  import banked_spi_seq_pkg::*;
#(
  parameter int         LEN_W     = 8,
  parameter logic [7:0] OPC_RD    = 8'h00,
  parameter logic [7:0] OPC_WR    = 8'h40,
  parameter logic [7:0] OPC_BSET  = 8'h80,
  parameter logic [7:0] OPC_BCLR  = 8'hA0,
  parameter logic [7:0] OPC_BRD   = 8'h3A,
  parameter logic [7:0] OPC_BWR   = 8'h7A,
  parameter logic [4:0] BANK_REG  = 5'h1F,
  parameter logic [7:0] BANK_MASK = 8'h03
) (
  input  step_e            step_i,
  input  op_e              op_i,
  input  logic [7:0]       addr_i,
  input  logic [15:0]      wdata_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] idx_i,
  output logic [7:0]       tx_o,
  output logic             last_o,
  output logic             capture_o,
  output logic             take_o
);
  logic [LEN_W-1:0] last_idx;
  logic [7:0]       cmd;
  logic [7:0]       data;
  logic [7:0]       reg_lo, reg_hi;
  logic [4:0]       addr_hi;

  assign addr_hi = addr_i[4:0] + 5'd1;
  assign reg_lo  = {3'b000, addr_i[4:0]};
  assign reg_hi  = {3'b000, addr_hi};

  always_comb begin
    last_idx = LEN_W'(1);
    cmd      = OPC_WR | reg_lo;
    data     = wdata_i[7:0];
    unique case (step_i)
      STEP_BCLR: begin
        cmd  = OPC_BCLR | {3'b000, BANK_REG};
        data = BANK_MASK;
      end
      STEP_BSET: begin
        cmd  = OPC_BSET | {3'b000, BANK_REG};
        data = {6'b0, addr_i[6:5]};
      end
      STEP_HIGH: begin
        cmd  = OPC_WR | reg_hi;
        data = wdata_i[15:8];
      end
      default: begin
        unique case (op_i)
          OP_RD: begin
            cmd      = OPC_RD | reg_lo;
            data     = 8'h00;
            last_idx = addr_i[7] ? LEN_W'(2) : LEN_W'(1);
          end
          OP_BSET: cmd = OPC_BSET | reg_lo;
          OP_BCLR: cmd = OPC_BCLR | reg_lo;
          OP_BUF_RD: begin
            cmd      = OPC_BRD;
            data     = 8'h00;
            last_idx = len_i;
          end
          OP_BUF_WR: begin
            cmd      = OPC_BWR;
            last_idx = len_i;
          end
          default: cmd = OPC_WR | reg_lo;
        endcase
      end
    endcase
  end

  assign tx_o      = (idx_i == '0) ? cmd : data;
  assign last_o    = (idx_i == last_idx);
  assign capture_o = (step_i == STEP_MAIN) && (idx_i != '0) &&
                     (((op_i == OP_RD) && (idx_i == last_idx)) || (op_i == OP_BUF_RD));
  assign take_o    = (step_i == STEP_MAIN) && (idx_i != '0) && (op_i == OP_BUF_WR);
endmodule

// File: rtl/banked_spi_seq_ctrl.sv
module banked_spi_seq_ctrl
  import banked_spi_seq_pkg::*;
#(
  parameter int         SCK_DIV   = 4,
  parameter int         LEN_W     = 8,
  parameter logic [7:0] OPC_RD    = 8'h00,
  parameter logic [7:0] OPC_WR    = 8'h40,
  parameter logic [7:0] OPC_BSET  = 8'h80,
  parameter logic [7:0] OPC_BCLR  = 8'hA0,
  parameter logic [7:0] OPC_BRD   = 8'h3A,
  parameter logic [7:0] OPC_BWR   = 8'h7A,
  parameter logic [4:0] BANK_REG  = 5'h1F,
  parameter logic [7:0] BANK_MASK = 8'h03
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2:0]       op_i,
  input  logic [7:0]       addr_i,
  input  logic [15:0]      wdata_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o,
  output logic             wtake_o,
  output logic             cs_no,
  output logic             sh_start_o,
  output logic [7:0]       sh_tx_o,
  input  logic             sh_done_i,
  input  logic [7:0]       sh_rx_i
);
  localparam int GAP_W = $clog2(SCK_DIV);

  state_e           st_q;
  step_e            step_q;
  op_e              op_q, op_in;
  logic [7:0]       addr_q;
  logic [15:0]      wdata_q, frm_wdata;
  logic [LEN_W-1:0] len_q, idx_q;
  logic [GAP_W-1:0] gap_q;
  logic             busy_q, done_q, rvalid_q, wtake_q, cs_nq, start_q;
  logic [7:0]       rdata_q, tx_q;

  logic [7:0] frm_tx;
  logic       frm_last, frm_cap, frm_take;
  logic [1:0] bank_sel;
  logic       bank_match, bank_load;

  assign op_in     = op_e'(op_i);
  assign bank_sel  = (st_q == ST_IDLE) ? addr_i[6:5] : addr_q[6:5];
  assign bank_load = (st_q == ST_BYTE) && sh_done_i && frm_last && (step_q == STEP_BSET);
  assign frm_wdata = (op_q == OP_BUF_WR) ? {wdata_q[15:8], wdata_i[7:0]} : wdata_q;

  banked_spi_seq_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bank_i  (bank_sel),
    .load_i  (bank_load),
    .match_o (bank_match)
  );

  banked_spi_seq_frame #(
    .LEN_W(LEN_W), .OPC_RD(OPC_RD), .OPC_WR(OPC_WR), .OPC_BSET(OPC_BSET),
    .OPC_BCLR(OPC_BCLR), .OPC_BRD(OPC_BRD), .OPC_BWR(OPC_BWR),
    .BANK_REG(BANK_REG), .BANK_MASK(BANK_MASK)
  ) u_frame (
    .step_i    (step_q),
    .op_i      (op_q),
    .addr_i    (addr_q),
    .wdata_i   (frm_wdata),
    .len_i     (len_q),
    .idx_i     (idx_q),
    .tx_o      (frm_tx),
    .last_o    (frm_last),
    .capture_o (frm_cap),
    .take_o    (frm_take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      step_q   <= STEP_MAIN;
      op_q     <= OP_NONE;
      addr_q   <= '0;
      wdata_q  <= '0;
      len_q    <= '0;
      idx_q    <= '0;
      gap_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rvalid_q <= 1'b0;
      wtake_q  <= 1'b0;
      cs_nq    <= 1'b1;
      start_q  <= 1'b0;
      rdata_q  <= '0;
      tx_q     <= '0;
    end else begin
      start_q  <= 1'b0;
      done_q   <= 1'b0;
      rvalid_q <= 1'b0;
      wtake_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_i && (op_in != OP_NONE)) begin
            op_q    <= op_in;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            len_q   <= len_i;
            idx_q   <= '0;
            busy_q  <= 1'b1;
            step_q  <= (is_stream(op_in) || bank_match) ? STEP_MAIN : STEP_BCLR;
            st_q    <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          cs_nq   <= 1'b0;
          start_q <= 1'b1;
          tx_q    <= frm_tx;
          wtake_q <= frm_take;
          st_q    <= ST_BYTE;
        end
        ST_BYTE: begin
          if (sh_done_i) begin
            if (frm_cap) begin
              rdata_q  <= sh_rx_i;
              rvalid_q <= 1'b1;
            end
            if (frm_last) begin
              cs_nq <= 1'b1;
              gap_q <= '0;
              st_q  <= ST_GAP;
            end else begin
              idx_q <= idx_q + LEN_W'(1);
              st_q  <= ST_LOAD;
            end
          end
        end
        default: begin
          if (gap_q == GAP_W'(SCK_DIV - 1)) begin
            idx_q <= '0;
            st_q  <= ST_LOAD;
            unique case (step_q)
              STEP_BCLR: step_q <= STEP_BSET;
              STEP_BSET: step_q <= STEP_MAIN;
              STEP_MAIN: begin
                if (op_q == OP_PAIR) begin
                  step_q <= STEP_HIGH;
                end else begin
                  st_q   <= ST_IDLE;
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                end
              end
              default: begin
                st_q   <= ST_IDLE;
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end
            endcase
          end else begin
            gap_q <= gap_q + GAP_W'(1);
          end
        end
      endcase
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;
  assign wtake_o    = wtake_q;
  assign cs_no      = cs_nq;
  assign sh_start_o = start_q;
  assign sh_tx_o    = tx_q;
endmodule

// File: rtl/banked_spi_seq.sv
module banked_spi_seq #(
  parameter int         SCK_DIV   = 4,
  parameter int         LEN_W     = 8,
  parameter logic [7:0] OPC_RD    = 8'h00,
  parameter logic [7:0] OPC_WR    = 8'h40,
  parameter logic [7:0] OPC_BSET  = 8'h80,
  parameter logic [7:0] OPC_BCLR  = 8'hA0,
  parameter logic [7:0] OPC_BRD   = 8'h3A,
  parameter logic [7:0] OPC_BWR   = 8'h7A,
  parameter logic [4:0] BANK_REG  = 5'h1F,
  parameter logic [7:0] BANK_MASK = 8'h03
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2:0]       op_i,
  input  logic [7:0]       addr_i,
  input  logic [15:0]      wdata_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o,
  output logic             wtake_o,
  output logic             cs_no,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  logic       sh_start, sh_done;
  logic [7:0] sh_tx, sh_rx;

  banked_spi_seq_ctrl #(
    .SCK_DIV(SCK_DIV), .LEN_W(LEN_W), .OPC_RD(OPC_RD), .OPC_WR(OPC_WR),
    .OPC_BSET(OPC_BSET), .OPC_BCLR(OPC_BCLR), .OPC_BRD(OPC_BRD),
    .OPC_BWR(OPC_BWR), .BANK_REG(BANK_REG), .BANK_MASK(BANK_MASK)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .op_i       (op_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .len_i      (len_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o),
    .wtake_o    (wtake_o),
    .cs_no      (cs_no),
    .sh_start_o (sh_start),
    .sh_tx_o    (sh_tx),
    .sh_done_i  (sh_done),
    .sh_rx_i    (sh_rx)
  );

  banked_spi_seq_shift #(.SCK_DIV(SCK_DIV)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .tx_i    (sh_tx),
    .miso_i  (miso_i),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .rx_o    (sh_rx),
    .done_o  (sh_done)
  );
endmodule

// File: rtl/banked_spi_seq_chk.sv
module banked_spi_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic [2:0] op_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       cs_no,
  input logic       sck_o,
  input logic       mosi_o,
  input logic       rvalid_o,
  input logic       wtake_o
);
  // R9: clock parked low outside a frame
  a_r9_sck_low_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
  // R9: clock edges only inside a frame
  a_r9_sck_moves_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sck_o) |-> !cs_no);
  // R9: chip select high for more than one cycle after each frame
  a_r9_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);
  // R1: data line held while clock high
  a_r1_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));
  // R10: done is a single pulse ending busy
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  // R10: acceptance only from a valid request
  a_r10_accept_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(req_i) && ($past(op_i) != 3'd7)));
  // R11: idle outputs quiet
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o) |-> (cs_no && !rvalid_o && !wtake_o));
endmodule

bind banked_spi_seq banked_spi_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .op_i     (op_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .cs_no    (cs_no),
  .sck_o    (sck_o),
  .mosi_o   (mosi_o),
  .rvalid_o (rvalid_o),
  .wtake_o  (wtake_o)
);

// File: tb/banked_spi_seq_test.sv
module banked_spi_seq_test;
  localparam int DIV = 4;
  localparam int LW  = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic [2:0]    op_i = '0;
  logic [7:0]    addr_i = '0;
  logic [15:0]   wdata_i = '0;
  logic [LW-1:0] len_i = '0;
  logic          busy_o, done_o, rvalid_o, wtake_o, cs_no, sck_o, mosi_o;
  logic [7:0]    rdata_o;
  logic          miso_i = 1'b0;

  always #10 clk_i = ~clk_i;

  banked_spi_seq #(.SCK_DIV(DIV), .LEN_W(LW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .len_i(len_i), .busy_o(busy_o), .done_o(done_o),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .wtake_o(wtake_o), .cs_no(cs_no),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int f, input int b);
    return 8'((f * 29 + b * 53 + 150) & 255);
  endfunction

  // slave model
  logic [7:0] fb [0:7][0:31];
  int         flen [0:7];
  int         nfr = 0, cur = 0, bit_in = 0, out_bits = 0;
  bit         in_fr = 1'b0;
  logic [7:0] sr = '0;

  always @(negedge cs_no) begin
    cur = nfr; in_fr = 1'b1; bit_in = 0; out_bits = 0;
    if (cur < 8) flen[cur] = 0;
    miso_i = resp(cur, 0)[7];
  end
  always @(posedge cs_no) begin
    if (in_fr) begin nfr++; in_fr = 1'b0; end
  end
  always @(posedge sck_o) begin
    if (cs_no === 1'b0) begin
      sr = {sr[6:0], mosi_o};
      bit_in++;
      if (bit_in == 8) begin
        bit_in = 0;
        if (cur < 8 && flen[cur] < 32) begin fb[cur][flen[cur]] = sr; flen[cur]++; end
      end
    end
  end
  always @(negedge sck_o) begin
    if (cs_no === 1'b0) begin
      out_bits++;
      miso_i = resp(cur, out_bits / 8)[7 - (out_bits % 8)];
    end
  end

  // host-side logs
  logic [7:0] rd [0:31];
  int         nrd = 0;
  logic [7:0] wb [0:31];
  int         wptr = 0;
  int         hi_run = 0, min_gap = 1000000;
  bit         sck_bad = 1'b0;

  always @(negedge clk_i) begin
    if (rvalid_o === 1'b1 && nrd < 32) begin rd[nrd] = rdata_o; nrd++; end
    if (wtake_o === 1'b1) begin
      wptr++;
      wdata_i[7:0] = wb[wptr % 32];
    end
    if (rst_ni) begin
      if (cs_no === 1'b1) hi_run++;
      else begin
        if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
        hi_run = 0;
      end
      if (cs_no === 1'b1 && sck_o === 1'b1) sck_bad = 1'b1;
    end
  end

  // expectation model
  logic [7:0] eb [0:7][0:31];
  int         elen [0:7];
  int         en = 0;
  logic [7:0] erd [0:31];
  int         enrd = 0;
  bit         mv = 1'b0;
  logic [1:0] mb = '0;

  task automatic ef_new();
    en++; elen[en-1] = 0;
  endtask
  task automatic ef_put(input logic [7:0] b);
    eb[en-1][elen[en-1]] = b; elen[en-1]++;
  endtask

  task automatic run(input logic [2:0] op, input logic [7:0] a, input logic [15:0] wd,
                     input int len, input bit poke, input string tag);
    int  t;
    bit  ok;
    nfr = 0; nrd = 0; wptr = 0; en = 0; enrd = 0;
    for (int i = 0; i < 32; i++) wb[i] = 8'($urandom);
    wdata_i = (op == 3'd6) ? {wd[15:8], wb[0]} : wd;
    if (op <= 3'd4 && !(mv && mb == a[6:5])) begin
      ef_new(); ef_put(8'hBF); ef_put(8'h03);
      ef_new(); ef_put(8'h9F); ef_put({6'b0, a[6:5]});
      mv = 1'b1; mb = a[6:5];
    end
    ef_new();
    case (op)
      3'd0: begin
        ef_put({3'b000, a[4:0]});
        if (a[7]) ef_put(8'h00);
        ef_put(8'h00);
        erd[0] = resp(en - 1, a[7] ? 2 : 1); enrd = 1;
      end
      3'd1: begin ef_put(8'h40 | {3'b0, a[4:0]}); ef_put(wd[7:0]); end
      3'd2: begin ef_put(8'h80 | {3'b0, a[4:0]}); ef_put(wd[7:0]); end
      3'd3: begin ef_put(8'hA0 | {3'b0, a[4:0]}); ef_put(wd[7:0]); end
      3'd4: begin
        ef_put(8'h40 | {3'b0, a[4:0]}); ef_put(wd[7:0]);
        ef_new(); ef_put(8'h40 | {3'b0, 5'(a[4:0] + 5'd1)}); ef_put(wd[15:8]);
      end
      3'd5: begin
        ef_put(8'h3A);
        for (int i = 0; i < len; i++) begin ef_put(8'h00); erd[i] = resp(en - 1, i + 1); end
        enrd = len;
      end
      default: begin
        ef_put(8'h7A);
        for (int i = 0; i < len; i++) ef_put(wb[i]);
      end
    endcase
    @(negedge clk_i);
    req_i = 1'b1; op_i = op; addr_i = a; len_i = LW'(len);
    @(negedge clk_i);
    req_i = 1'b0;
    chk(busy_o === 1'b1, {tag, " R10 busy after accept"}, int'(busy_o), 1);
    if (poke) begin
      repeat (6) @(negedge clk_i);
      req_i = 1'b1; op_i = 3'd6; addr_i = 8'h00; len_i = LW'(3);
      @(negedge clk_i);
      req_i = 1'b0;
    end
    t = 0;
    while (done_o !== 1'b1 && t < 30000) begin @(negedge clk_i); t++; end
    chk(t < 30000, {tag, " R10 done seen"}, t, 0);
    chk(busy_o === 1'b0, {tag, " R10 busy low at done"}, int'(busy_o), 0);
    repeat (DIV + 3) @(negedge clk_i);
    ok = (nfr == en);
    for (int f = 0; f < en && f < 8 && ok; f++) begin
      if (flen[f] != elen[f]) ok = 1'b0;
      for (int b = 0; b < elen[f] && ok; b++) if (fb[f][b] !== eb[f][b]) ok = 1'b0;
    end
    chk(ok, {tag, " frames"}, nfr, en);
    ok = (nrd == enrd);
    for (int i = 0; i < enrd && ok; i++) if (rd[i] !== erd[i]) ok = 1'b0;
    chk(ok, {tag, " read data"}, (nrd > 0) ? int'(rd[0]) : -1, (enrd > 0) ? int'(erd[0]) : -1);
    if (poke) chk(busy_o === 1'b0 && nfr == en, {tag, " R10 busy request ignored"}, nfr, en);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(cs_no === 1'b1 && sck_o === 1'b0, "R11 cs/sck in reset", {cs_no, sck_o}, 2);
    chk(busy_o === 1'b0 && done_o === 1'b0 && rvalid_o === 1'b0 && wtake_o === 1'b0,
        "R11 handshake in reset", {busy_o, done_o, rvalid_o, wtake_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(cs_no === 1'b1 && sck_o === 1'b0 && busy_o === 1'b0, "R11 after reset",
        {cs_no, sck_o, busy_o}, 4);

    run(3'd1, 8'h25, 16'h00C4, 0, 1'b0, "R2 R3 first access switches, R5 write");
    run(3'd1, 8'h33, 16'h0011, 0, 1'b0, "R3 same bank no switch");
    run(3'd2, 8'h2A, 16'h0081, 0, 1'b0, "R5 bit set");
    run(3'd0, 8'hC5, 16'h0000, 0, 1'b0, "R4 dummy read bit7");
    run(3'd0, 8'h45, 16'h0000, 0, 1'b0, "R4 plain read");
    run(3'd3, 8'h07, 16'h00F0, 0, 1'b0, "R2 bank 0 switch, R5 bit clear");
    run(3'd4, 8'h1F, 16'hBEEF, 0, 1'b0, "R6 pair write wrap");
    run(3'd4, 8'h64, 16'h1234, 0, 1'b0, "R6 pair write with switch");
    run(3'd5, 8'h00, 16'h0000, 0, 1'b0, "R7 buffer read len 0");
    run(3'd5, 8'h00, 16'h0000, 5, 1'b0, "R7 buffer read len 5");
    run(3'd6, 8'h00, 16'h0000, 4, 1'b0, "R8 buffer write len 4");
    run(3'd1, 8'h6E, 16'h005A, 0, 1'b0, "R3 stream kept bank");
    run(3'd1, 8'h10, 16'h0033, 0, 1'b1, "R10 request while busy");

    // R10 op 7 never accepted
    nfr = 0;
    @(negedge clk_i);
    req_i = 1'b1; op_i = 3'd7; addr_i = 8'h12;
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (20) @(negedge clk_i);
    chk(busy_o === 1'b0 && nfr == 0 && !in_fr, "R10 op 7 ignored", nfr, 0);

    for (int k = 0; k < 120; k++) begin
      run(3'($urandom_range(0, 6)), 8'($urandom), 16'($urandom),
          $urandom_range(0, 12), 1'b0, "R1 random mix");
    end

    chk(min_gap >= DIV, "R9 cs high gap", min_gap, DIV);
    chk(!sck_bad, "R9 sck low while cs high", int'(sck_bad), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule